// File: doc/BRIEF.md
# Audio Sample Bridge FIFO

This block sits between a DMA engine and a downstream audio-link consumer. A DMA engine (or software) writes 32-bit audio samples (24-bit or 32-bit left-justified content, any channel count from 1 to 8, interleaved by the writer) into a data register. The samples queue in a 32-entry buffer, and the consumer drains them in order through a valid/ready sample port. The block has no knowledge of channel layout. It moves words only.

A DMA request line tells the DMA engine when the buffer wants more data. The request is driven by the buffer fill level, compared against programmable low and high watermarks, under a selectable trigger mode. Three sticky event flags are kept: overflow, below-low-watermark and above-high-watermark. Each flag can be blocked by a mask bit, and the unmasked flags are ORed onto one interrupt line.

The block is programmed through a simple 32-bit register bus with a write strobe and combinational read data. The expected start order is module enable first, then DMA enable. The stop order is the reverse.

Top module: `aud_sample_bridge`

## Requirements
- R1: After reset, every register reads zero, and `dma_req`, `irq` and `smp_valid` are low.
- R2: Register word offsets are fixed as follows:
  - 0x00 control: bit 0 is the module enable.
  - 0x04 extended control: bit 0 is the DMA enable, bits 2:1 are the trigger mode, bits 20:16 are the low watermark and bits 28:24 are the high watermark.
  - 0x08 sample data: write-only, reads as zero.
  - 0x0C status: read-only, and writes to it have no effect.
  - 0x10 raw flags.
  - 0x14 masked flags.
  - 0x18 mask.
- R3: Samples leave on `smp_data` in the order they were written. `smp_valid` is high only while the module is enabled and the buffer is not empty, and one entry is removed on each cycle with `smp_valid` and `smp_ready` both high.
- R4: Status bits 5:0 give the current fill count, from 0 to 32.
- R5: A data write while the buffer holds 32 entries is dropped, leaves the stored samples intact and sets raw flag bit 0 (overflow).
- R6: `dma_req` is high only when both the module enable and the DMA enable are set. In trigger mode 0 it is high while the fill count is below the low watermark.
- R7: In trigger mode 1, `dma_req` is high while the fill count is at or below the high watermark. Trigger modes 2 and 3 never raise `dma_req`.
- R8: While the module is enabled, raw flag bit 1 is set whenever the fill count is below the low watermark, and bit 2 is set whenever it is above the high watermark. Raw flags are sticky and are cleared by writing 1 to the matching bit. A set condition in the same cycle wins over the clear.
- R9: The masked flag register reads as raw AND NOT mask, with mask bit 0 covering overflow, bit 1 covering low and bit 2 covering high. `irq` is the OR of the masked bits.
- R10: While the module enable is clear, the buffer is emptied and data writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| smp_valid | output | 1 | A sample is available |
| smp_ready | input | 1 | Consumer accepts the sample |
| smp_data | output | 32 | Oldest buffered sample |
| dma_req | output | 1 | DMA request for more samples |
| irq | output | 1 | OR of the unmasked event flags |

## Verification
The hardest state to reach is a full buffer with its stored order still observable. Reaching it needs enough writes to cross both watermarks, an extra write that must be dropped, and then reads that show the original samples survived.

The stimulus works in three steps:
- It first clears the raw flags and fills the buffer from a known partial level. It checks that overflow is still clear at exactly 32 entries.
- It then issues the one extra write, and confirms that the count stays at 32 and that the overflow flag rises.
- It finally pops the head entry to show that the expected older sample is still next.

Set-over-clear priority is reached by clearing the low flag while the fill count is still below the low watermark.

// File: rtl/asb_pkg.sv
package asb_pkg;
  localparam int REG_W = 32;
  localparam int WM_W  = 5;
  localparam int FLG_N = 3;

  // word index decoded from reg_addr[4:2]
  localparam logic [2:0] IDX_CTRL  = 3'd0;
  localparam logic [2:0] IDX_XCTRL = 3'd1;
  localparam logic [2:0] IDX_DATA  = 3'd2;
  localparam logic [2:0] IDX_STAT  = 3'd3;
  localparam logic [2:0] IDX_RAW   = 3'd4;
  localparam logic [2:0] IDX_MSKD  = 3'd5;
  localparam logic [2:0] IDX_MASK  = 3'd6;

  // extended control field positions
  localparam int XC_DMA_BIT = 0;
  localparam int XC_TRG_LSB = 1;
  localparam int XC_WL_LSB  = 16;
  localparam int XC_WH_LSB  = 24;

  // flag bit positions
  localparam int FLG_OVF  = 0;
  localparam int FLG_LOW  = 1;
  localparam int FLG_HIGH = 2;

  typedef enum logic [1:0] {
    TRIG_BELOW_LOW = 2'd0,
    TRIG_UPTO_HIGH = 2'd1,
    TRIG_OFF_A     = 2'd2,
    TRIG_OFF_B     = 2'd3
  } trig_e;
endpackage

// File: rtl/asb_fifo.sv
module asb_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/asb_level_mon.sv
module asb_level_mon
  import asb_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic [CW-1:0]   count,
  input  logic [WM_W-1:0] wm_low,
  input  logic [WM_W-1:0] wm_high,
  input  trig_e           mode,
  input  logic            mod_en,
  input  logic            dma_en,
  output logic            dma_req,
  output logic            below_low,
  output logic            above_high
);
  logic want;

  assign below_low  = (count <  CW'(wm_low));
  assign above_high = (count >  CW'(wm_high));

  always_comb begin
    case (mode)
      TRIG_BELOW_LOW: want = below_low;
      TRIG_UPTO_HIGH: want = !above_high;
      default:        want = 1'b0;
    endcase
  end

  assign dma_req = mod_en && dma_en && want;
endmodule

// File: rtl/asb_irq_flags.sv
module asb_irq_flags
  import asb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_N-1:0] set_ev,
  input  logic [FLG_N-1:0] clr_w1c,
  input  logic [FLG_N-1:0] mask,
  output logic [FLG_N-1:0] raw,
  output logic [FLG_N-1:0] masked,
  output logic             irq
);
  logic [FLG_N-1:0] raw_q, raw_d;

  always_comb raw_d = (raw_q & ~clr_w1c) | set_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw    = raw_q;
  assign masked = raw_q & ~mask;
  assign irq    = |masked;
endmodule

// File: rtl/aud_sample_bridge.sv
module aud_sample_bridge
  import asb_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [REG_W-1:0]  smp_data,
  output logic              dma_req,
  output logic              irq
);
  logic             mod_en_q, mod_en_d;
  logic             dma_en_q, dma_en_d;
  logic [1:0]       trig_q, trig_d;
  logic [WM_W-1:0]  wl_q, wl_d, wh_q, wh_d;
  logic [FLG_N-1:0] mask_q, mask_d;

  logic [2:0]       idx;
  logic             aligned;
  logic             wr_ctrl, wr_xctrl, wr_data, wr_raw, wr_mask;

  logic [CW-1:0]    fill;
  logic             full, empty, push, pop, flush;
  logic             below_low, above_high;
  logic [FLG_N-1:0] set_ev, clr_w1c, raw, masked;
  trig_e            mode;

  assign idx      = reg_addr[4:2];
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign wr_ctrl  = reg_we && aligned && (idx == IDX_CTRL);
  assign wr_xctrl = reg_we && aligned && (idx == IDX_XCTRL);
  assign wr_data  = reg_we && aligned && (idx == IDX_DATA);
  assign wr_raw   = reg_we && aligned && (idx == IDX_RAW);
  assign wr_mask  = reg_we && aligned && (idx == IDX_MASK);

  // control next state
  always_comb begin
    mod_en_d = mod_en_q;
    dma_en_d = dma_en_q;
    trig_d   = trig_q;
    wl_d     = wl_q;
    wh_d     = wh_q;
    mask_d   = mask_q;
    if (wr_ctrl) mod_en_d = reg_wdata[0];
    if (wr_xctrl) begin
      dma_en_d = reg_wdata[XC_DMA_BIT];
      trig_d   = reg_wdata[XC_TRG_LSB +: 2];
      wl_d     = reg_wdata[XC_WL_LSB +: WM_W];
      wh_d     = reg_wdata[XC_WH_LSB +: WM_W];
    end
    if (wr_mask) mask_d = reg_wdata[FLG_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_en_q <= 1'b0;
      dma_en_q <= 1'b0;
      trig_q   <= '0;
      wl_q     <= '0;
      wh_q     <= '0;
      mask_q   <= '0;
    end else begin
      mod_en_q <= mod_en_d;
      dma_en_q <= dma_en_d;
      trig_q   <= trig_d;
      wl_q     <= wl_d;
      wh_q     <= wh_d;
      mask_q   <= mask_d;
    end
  end

  assign mode      = trig_e'(trig_q);
  assign flush     = !mod_en_q;
  assign push      = wr_data && mod_en_q && !full;
  assign smp_valid = mod_en_q && !empty;
  assign pop       = smp_valid && smp_ready;

  asb_fifo #(.DEPTH(DEPTH), .DW(REG_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .din   (reg_wdata),
    .pop   (pop),
    .dout  (smp_data),
    .count (fill),
    .full  (full),
    .empty (empty)
  );

  asb_level_mon #(.CW(CW)) u_level (
    .count      (fill),
    .wm_low     (wl_q),
    .wm_high    (wh_q),
    .mode       (mode),
    .mod_en     (mod_en_q),
    .dma_en     (dma_en_q),
    .dma_req    (dma_req),
    .below_low  (below_low),
    .above_high (above_high)
  );

  always_comb begin
    set_ev           = '0;
    set_ev[FLG_OVF]  = wr_data && mod_en_q && full;
    set_ev[FLG_LOW]  = mod_en_q && below_low;
    set_ev[FLG_HIGH] = mod_en_q && above_high;
    clr_w1c          = wr_raw ? reg_wdata[FLG_N-1:0] : '0;
  end

  asb_irq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .clr_w1c (clr_w1c),
    .mask    (mask_q),
    .raw     (raw),
    .masked  (masked),
    .irq     (irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (idx)
        IDX_CTRL:  reg_rdata[0] = mod_en_q;
        IDX_XCTRL: begin
          reg_rdata[XC_DMA_BIT]         = dma_en_q;
          reg_rdata[XC_TRG_LSB +: 2]    = trig_q;
          reg_rdata[XC_WL_LSB +: WM_W]  = wl_q;
          reg_rdata[XC_WH_LSB +: WM_W]  = wh_q;
        end
        IDX_STAT:  reg_rdata = REG_W'(fill);
        IDX_RAW:   reg_rdata = REG_W'(raw);
        IDX_MSKD:  reg_rdata = REG_W'(masked);
        IDX_MASK:  reg_rdata = REG_W'(mask_q);
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/asb_checker.sv
module asb_checker #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          dma_en,
  input logic          dma_req,
  input logic          irq,
  input logic [2:0]    mask,
  input logic [2:0]    raw,
  input logic [CW-1:0] fill,
  input logic          full,
  input logic          data_wr,
  input logic          smp_valid
);
  // R4: fill count never exceeds the buffer depth
  a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // R6: no request without both enables
  a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && dma_en) |-> !dma_req);

  // R9: all sources masked keeps the interrupt low
  a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  // R10: a disabled module holds an empty buffer
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fill == '0));

  // R5: a write into a full buffer raises overflow
  a_r5_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && en && full) |=> raw[0]);

  // R3: valid only with data present and the module enabled
  a_r3_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (en && fill != '0));
endmodule

bind aud_sample_bridge asb_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (mod_en_q),
  .dma_en    (dma_en_q),
  .dma_req   (dma_req),
  .irq       (irq),
  .mask      (mask_q),
  .raw       (raw),
  .fill      (fill),
  .full      (full),
  .data_wr   (wr_data),
  .smp_valid (smp_valid)
);

// File: tb/aud_sample_bridge_test.sv
module aud_sample_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        smp_valid;
  logic        smp_ready = 1'b0;
  logic [31:0] smp_data;
  logic        dma_req;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aud_sample_bridge uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .dma_req   (dma_req),
    .irq       (irq)
  );

  // row: req[3:0] op[1:0] addr[4:0] data[31:0] exp[31:0]
  // op 0 write, 1 read-compare, 2 pop-compare, 3 pins {smp_valid,irq,dma_req}
  localparam int NV = 33;
  localparam logic [74:0] VEC [NV] = '{
    {4'd0, 2'd0, 5'h00, 32'h0000_0001, 32'h0},          // enable
    {4'd0, 2'd0, 5'h04, 32'h0604_0001, 32'h0},          // wl 4, wh 6, mode 0, dma on
    {4'd2, 2'd1, 5'h04, 32'h0, 32'h0604_0001},          // R2 field readback
    {4'd6, 2'd3, 5'h00, 32'h0, 32'h0000_0003},          // R6 empty -> req, R8 low irq
    {4'd0, 2'd0, 5'h18, 32'h0000_0007, 32'h0},          // mask all
    {4'd9, 2'd3, 5'h00, 32'h0, 32'h0000_0001},          // R9 irq blocked
    {4'd8, 2'd1, 5'h10, 32'h0, 32'h0000_0002},          // R8 low flag raw
    {4'd9, 2'd1, 5'h14, 32'h0, 32'h0000_0000},          // R9 masked view
    {4'd0, 2'd0, 5'h08, 32'hA000_0001, 32'h0},
    {4'd0, 2'd0, 5'h08, 32'hA000_0002, 32'h0},
    {4'd0, 2'd0, 5'h08, 32'hA000_0003, 32'h0},
    {4'd0, 2'd0, 5'h08, 32'hA000_0004, 32'h0},
    {4'd0, 2'd0, 5'h08, 32'hA000_0005, 32'h0},
    {4'd4, 2'd1, 5'h0C, 32'h0, 32'h0000_0005},          // R4 count 5
    {4'd6, 2'd3, 5'h00, 32'h0, 32'h0000_0004},          // R6 count >= low -> no req
    {4'd0, 2'd0, 5'h10, 32'h0000_0002, 32'h0},          // clear low
    {4'd8, 2'd1, 5'h10, 32'h0, 32'h0000_0000},          // R8 W1C
    {4'd0, 2'd0, 5'h08, 32'hA000_0006, 32'h0},
    {4'd0, 2'd0, 5'h08, 32'hA000_0007, 32'h0},
    {4'd8, 2'd1, 5'h10, 32'h0, 32'h0000_0004},          // R8 high flag
    {4'd0, 2'd0, 5'h18, 32'h0000_0003, 32'h0},          // unmask high
    {4'd9, 2'd1, 5'h14, 32'h0, 32'h0000_0004},          // R9 masked high
    {4'd9, 2'd3, 5'h00, 32'h0, 32'h0000_0006},          // R9 irq up
    {4'd3, 2'd2, 5'h00, 32'h0, 32'hA000_0001},          // R3 order
    {4'd3, 2'd2, 5'h00, 32'h0, 32'hA000_0002},          // R3 order
    {4'd4, 2'd1, 5'h0C, 32'h0, 32'h0000_0005},          // R4 after pops
    {4'd0, 2'd0, 5'h0C, 32'hFFFF_FFFF, 32'h0},          // write to status
    {4'd2, 2'd1, 5'h0C, 32'h0, 32'h0000_0005},          // R2 status read-only
    {4'd2, 2'd1, 5'h08, 32'h0, 32'h0000_0000},          // R2 data reads zero
    {4'd0, 2'd0, 5'h04, 32'h0604_0003, 32'h0},          // mode 1
    {4'd7, 2'd3, 5'h00, 32'h0, 32'h0000_0007},          // R7 5 <= high -> req
    {4'd0, 2'd0, 5'h04, 32'h0604_0005, 32'h0},          // mode 2
    {4'd7, 2'd3, 5'h00, 32'h0, 32'h0000_0006}           // R7 mode 2 no req
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pins(input string req, input logic [2:0] exp);
    @(negedge clk);
    #1;
    chk(req, {29'b0, smp_valid, irq, dma_req}, {29'b0, exp});
  endtask

  task automatic popc(input string req, input logic [31:0] exp);
    @(negedge clk);
    #1;
    chk(req, {smp_valid ? smp_data : 32'hXXXX_XXXX}, exp);
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 7; i++) rd("R1", 5'(i * 4), 32'h0);
    pins("R1", 3'b000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VEC[i][74:71], i);
      case (VEC[i][70:69])
        2'd0: wr(VEC[i][68:64], VEC[i][63:32]);
        2'd1: rd(tag, VEC[i][68:64], VEC[i][31:0]);
        2'd2: popc(tag, VEC[i][31:0]);
        default: pins(tag, VEC[i][2:0]);
      endcase
    end

    // R3: order continues
    popc("R3", 32'hA000_0003);
    popc("R3", 32'hA000_0004);

    // R6: dma enable gating at count 3
    wr(5'h18, 32'h7);
    wr(5'h04, 32'h0604_0000);
    pins("R6", 3'b100);
    wr(5'h04, 32'h0604_0001);
    pins("R6", 3'b101);

    // R8: clear while below low -> low re-set, high cleared
    wr(5'h10, 32'h7);
    rd("R8", 5'h10, 32'h2);

    // R5: fill to 32, then overflow
    for (int k = 0; k < 29; k++) wr(5'h08, 32'hB000_0000 + 32'(k));
    rd("R4", 5'h0C, 32'd32);
    rd("R5", 5'h10, 32'h6);
    wr(5'h08, 32'hDEAD_BEEF);
    rd("R5", 5'h0C, 32'd32);
    rd("R5", 5'h10, 32'h7);
    popc("R5", 32'hA000_0005);

    // R10: disable flushes and ignores writes
    wr(5'h00, 32'h0);
    rd("R10", 5'h0C, 32'h0);
    pins("R10", 3'b000);
    wr(5'h08, 32'h1234_5678);
    rd("R10", 5'h0C, 32'h0);
    wr(5'h00, 32'h1);
    rd("R10", 5'h0C, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule